// File: doc/BRIEF.md
# Self-Configuring Multi-Protocol DAC Code Interface

This block holds the code register of a 256-step digital-to-analog converter. It accepts the setting from a host over one of three protocols and works out from pin activity which protocol is in use. In the increment-only pulse protocol, each clock pulse raises the code by one step. In the two-wire pulse protocol, a direction pin picks up or down for each pulse. In the standard serial protocol, an active-low select frames a transfer, a serial clock strobes the bits and a data-out line returns the old code while the new code shifts in.

The four host pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are found in the system clock domain. Once a protocol switch happens, it is sticky until the next reset. The block outputs the current code, the active protocol, and a data-out pin with its own tri-state enable.

Top module: `dac_code_autoif`

## Requirements
- R1: While reset is asserted and right after it, `code_o` is 0x80 (mid-scale), `mode_o` is 0, and `sdo_oe_o` and `sdo_o` are 0.
- R2: In mode 0 (increment-only, `mode_o`=0), each rising edge of `sclk_i` raises the code by exactly one. A pin change first sampled at system clock edge k shows on `code_o` after edge k+2.
- R3: Counting up in either pulse mode saturates at 0xFF and never wraps to 0x00.
- R4: While `sel_n_i` is high, the first time `updn_i` is seen low from mode 0, the block enters mode 1 (two-wire pulse, `mode_o`=1). Mode 1 never returns to mode 0 before reset.
- R5: In mode 1, a rising edge of `sclk_i` counts up when `updn_i` is high and down when it is low. Counting down saturates at 0x00 and never wraps to 0xFF.
- R6: The first time `sel_n_i` is seen low, from either pulse mode, the block enters mode 2 (serial, `mode_o`=2) and stays there until reset. In mode 2, `sclk_i` pulses while `sel_n_i` is high leave the code unchanged.
- R7: In mode 2, a falling edge of `sel_n_i` sets `sdo_oe_o` to 1 and presents bit 7 of the current code on `sdo_o`. Each later falling `sclk_i` edge presents the next lower bit.
- R8: On the rising edge of `sel_n_i`, if exactly 8 rising `sclk_i` edges occurred since the select fell, the code becomes the 8 `sdi_i` bits sampled at those edges, first bit as bit 7. `sdo_oe_o` returns to 0.
- R9: On the rising edge of `sel_n_i` after any number of rising `sclk_i` edges other than 8, the code is unchanged and `sdo_oe_o` returns to 0.
- R10: The mode decided in a cycle governs a pulse in that same cycle. A rising `sclk_i` edge seen in the cycle where `updn_i` is first seen low counts down. A rising `sclk_i` edge seen in the cycle where `sel_n_i` is first seen low makes no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Host select, active low (asynchronous) |
| sclk_i | input | 1 | Host pulse / serial clock (asynchronous) |
| updn_i | input | 1 | Host direction pin, high = up (asynchronous) |
| sdi_i | input | 1 | Host serial data in (asynchronous) |
| sdo_o | output | 1 | Serial data out, 0 while disabled |
| sdo_oe_o | output | 1 | Tri-state enable for the data-out pin |
| code_o | output | CODE_W | Current converter code |
| mode_o | output | 2 | Active protocol: 0 increment-only, 1 two-wire, 2 serial |

## Verification
Two events can land in the same system clock cycle: a protocol switch and a pulse edge. The bench provokes this by changing `updn_i`, or `sel_n_i`, at the same instant as a rising `sclk_i`, so that both pass the synchronisers together. A behavioural model then decides the result from R10: a down step in the first case and no step in the second. That model is compared with the outputs on every clock, together with explicit checks of the saturation limits and of serial transfers of 5, 8 and 9 bits.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
   typedef enum logic [1:0] {
      MODE_ONE = 2'd0,
      MODE_TWO = 2'd1,
      MODE_SER = 2'd2
   } if_mode_e;

   localparam int unsigned PIN_SEL = 0;
   localparam int unsigned PIN_CK  = 1;
   localparam int unsigned PIN_DIR = 2;
   localparam int unsigned PIN_DAT = 3;
   localparam int unsigned PIN_N   = 4;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
   parameter int unsigned N       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] lvl_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dac_pin_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], pin_i[b]};
      end
      assign lvl_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/dac_mode_fsm.sv
module dac_mode_fsm
   import dac_if_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sel_lvl_i,
   input  logic     dir_lvl_i,
   output if_mode_e eff_o,
   output if_mode_e mode_o
);
   if_mode_e mode_q;
   if_mode_e eff;

   always_comb begin
      eff = mode_q;
      if (mode_q != MODE_SER && !sel_lvl_i)      eff = MODE_SER;
      else if (mode_q == MODE_ONE && !dir_lvl_i) eff = MODE_TWO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_ONE;
      else        mode_q <= eff;
   end

   assign eff_o  = eff;
   assign mode_o = mode_q;
endmodule

// File: rtl/dac_code_step.sv
module dac_code_step
   import dac_if_pkg::*;
#(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  if_mode_e          mode_i,
   input  logic              ck_rise_i,
   input  logic              dir_lvl_i,
   input  logic              load_i,
   input  logic [CODE_W-1:0] load_val_i,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] TOP_CODE = '1;
   localparam logic [CODE_W-1:0] BOT_CODE = '0;

   logic [CODE_W-1:0] code_q;
   logic              go_up;

   assign go_up = (mode_i == MODE_ONE) || dir_lvl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= MID_CODE;
      end else if (load_i) begin
         code_q <= load_val_i;
      end else if (mode_i != MODE_SER && ck_rise_i) begin
         if (go_up) begin
            if (code_q != TOP_CODE) code_q <= code_q + 1'b1;
         end else begin
            if (code_q != BOT_CODE) code_q <= code_q - 1'b1;
         end
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/dac_serial_port.sv
module dac_serial_port
   import dac_if_pkg::*;
#(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  if_mode_e          mode_i,
   input  logic              sel_lvl_i,
   input  logic              sel_fall_i,
   input  logic              sel_rise_i,
   input  logic              ck_rise_i,
   input  logic              ck_fall_i,
   input  logic              din_i,
   input  logic [CODE_W-1:0] cur_i,
   output logic              load_o,
   output logic [CODE_W-1:0] load_val_o,
   output logic              dout_o,
   output logic              oe_o
);
   localparam int unsigned CNT_W = $clog2(CODE_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_W);
   localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(CODE_W + 1);

   logic              oe_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] in_sr;
   logic [CODE_W-1:0] out_sr;
   logic              ser;

   assign ser = (mode_i == MODE_SER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= 1'b0;
         cnt_q  <= '0;
         in_sr  <= '0;
         out_sr <= '0;
      end else if (ser) begin
         if (sel_fall_i) begin
            oe_q   <= 1'b1;
            cnt_q  <= '0;
            out_sr <= cur_i;
         end else if (sel_rise_i) begin
            oe_q <= 1'b0;
         end else if (oe_q && !sel_lvl_i) begin
            if (ck_rise_i) begin
               in_sr <= {in_sr[CODE_W-2:0], din_i};
               if (cnt_q != CNT_CAP) cnt_q <= cnt_q + 1'b1;
            end
            if (ck_fall_i) out_sr <= {out_sr[CODE_W-2:0], 1'b0};
         end
      end
   end

   assign load_o     = ser && sel_rise_i && oe_q && (cnt_q == CNT_FULL);
   assign load_val_o = in_sr;
   assign dout_o     = oe_q & out_sr[CODE_W-1];
   assign oe_o       = oe_q;
endmodule

// File: rtl/dac_code_autoif.sv
module dac_code_autoif
   import dac_if_pkg::*;
#(
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_i,
   input  logic              sclk_i,
   input  logic              updn_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [CODE_W-1:0] code_o,
   output logic [1:0]        mode_o
);
   if (CODE_W < 2) begin : g_bad_width
      $error("dac_code_autoif: CODE_W must be at least 2");
   end

   localparam logic [PIN_N-1:0] PIN_IDLE = PIN_N'(4'b0101);

   logic [PIN_N-1:0] raw;
   logic [PIN_N-1:0] lvl;
   logic [1:0]       prev_q;
   logic             sel_fall, sel_rise, ck_rise, ck_fall;
   if_mode_e         eff_mode, cur_mode;
   logic             load;
   logic [CODE_W-1:0] load_val;
   logic [CODE_W-1:0] code;

   assign raw[PIN_SEL] = sel_n_i;
   assign raw[PIN_CK]  = sclk_i;
   assign raw[PIN_DIR] = updn_i;
   assign raw[PIN_DAT] = sdi_i;

   dac_pin_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(raw), .lvl_o(lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= {PIN_IDLE[PIN_CK], PIN_IDLE[PIN_SEL]};
      else        prev_q <= {lvl[PIN_CK], lvl[PIN_SEL]};
   end

   assign sel_fall = prev_q[0] & ~lvl[PIN_SEL];
   assign sel_rise = ~prev_q[0] & lvl[PIN_SEL];
   assign ck_rise  = ~prev_q[1] & lvl[PIN_CK];
   assign ck_fall  = prev_q[1] & ~lvl[PIN_CK];

   dac_mode_fsm u_mode (
      .clk(clk), .rst_n(rst_n),
      .sel_lvl_i(lvl[PIN_SEL]), .dir_lvl_i(lvl[PIN_DIR]),
      .eff_o(eff_mode), .mode_o(cur_mode)
   );

   dac_serial_port #(.CODE_W(CODE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .mode_i(eff_mode),
      .sel_lvl_i(lvl[PIN_SEL]), .sel_fall_i(sel_fall), .sel_rise_i(sel_rise),
      .ck_rise_i(ck_rise), .ck_fall_i(ck_fall), .din_i(lvl[PIN_DAT]),
      .cur_i(code), .load_o(load), .load_val_o(load_val),
      .dout_o(sdo_o), .oe_o(sdo_oe_o)
   );

   dac_code_step #(.CODE_W(CODE_W)) u_code (
      .clk(clk), .rst_n(rst_n), .mode_i(eff_mode),
      .ck_rise_i(ck_rise), .dir_lvl_i(lvl[PIN_DIR]),
      .load_i(load), .load_val_i(load_val), .code_o(code)
   );

   assign code_o = code;
   assign mode_o = cur_mode;
endmodule

// File: rtl/dac_code_autoif_chk.sv
module dac_code_autoif_chk #(
   parameter int unsigned CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sdo_oe_o,
   input logic [CODE_W-1:0] code_o,
   input logic [1:0]        mode_o
);
   // R2
   pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd2 && $past(mode_o) != 2'd2) |->
      (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1 ||
       code_o == $past(code_o) - 1'b1));

   // R3
   no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(code_o) == {CODE_W{1'b1}} && mode_o != 2'd2) |-> code_o != {CODE_W{1'b0}});

   // R5
   no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(code_o) == {CODE_W{1'b0}} && mode_o != 2'd2) |-> code_o != {CODE_W{1'b1}});

   // R4
   two_wire_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == 2'd1) |-> mode_o != 2'd0);

   // R6
   serial_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == 2'd2) |-> mode_o == 2'd2);

   // R7
   oe_only_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe_o |-> mode_o == 2'd2);

   // R8
   serial_load_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd2 && $past(mode_o) == 2'd2 && code_o != $past(code_o)) |->
      $fell(sdo_oe_o));
endmodule

bind dac_code_autoif dac_code_autoif_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sdo_oe_o(sdo_oe_o), .code_o(code_o), .mode_o(mode_o)
);

// File: tb/sim_dac_code_autoif.sv
module sim_dac_code_autoif;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, sclk = 1'b0, updn = 1'b1, sdi = 1'b0;
   logic sdo, sdo_oe;
   logic [7:0] code;
   logic [1:0] mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R1";
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_code_autoif u0 (
      .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk),
      .updn_i(updn), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
      .code_o(code), .mode_o(mode)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference: pins delayed by two samples, then edge/level rules
   int s1[4], s2[4], pv[4];
   int m_code, m_mode, m_oe, m_cnt;
   int in_q[$];
   int out_q[$];

   task automatic model_reset();
      s1 = '{1, 0, 1, 0}; s2 = '{1, 0, 1, 0}; pv = '{1, 0, 1, 0};
      m_code = 128; m_mode = 0; m_oe = 0; m_cnt = 0;
      in_q.delete(); out_q.delete();
   endtask

   initial model_reset();

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         model_reset();
      end else begin
         int eff;
         bit sf, sr, cr, cf;
         sf = (pv[0] == 1 && s2[0] == 0);
         sr = (pv[0] == 0 && s2[0] == 1);
         cr = (pv[1] == 0 && s2[1] == 1);
         cf = (pv[1] == 1 && s2[1] == 0);
         eff = m_mode;
         if (m_mode != 2 && s2[0] == 0) eff = 2;
         else if (m_mode == 0 && s2[2] == 0) eff = 1;
         if (eff != 2) begin
            if (cr) begin
               if (eff == 0 || s2[2] == 1) begin if (m_code < 255) m_code++; end
               else begin if (m_code > 0) m_code--; end
            end
         end else if (sf) begin
            m_oe = 1; m_cnt = 0; out_q.delete();
            for (int i = 7; i >= 0; i--) out_q.push_back((m_code >> i) & 1);
         end else if (sr) begin
            if (m_oe == 1 && m_cnt == 8) begin
               m_code = 0;
               foreach (in_q[i]) m_code = m_code * 2 + in_q[i];
            end
            m_oe = 0;
         end else if (m_oe == 1 && s2[0] == 0) begin
            if (cr) begin
               in_q.push_back(s2[3]);
               if (in_q.size() > 8) void'(in_q.pop_front());
               m_cnt++;
            end
            if (cf && out_q.size() > 0) void'(out_q.pop_front());
         end
         m_mode = eff;
         pv = s2; s2 = s1;
         s1 = '{int'(sel_n), int'(sclk), int'(updn), int'(sdi)};
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({phase, " model code"}, code, m_code);
         chk({phase, " model mode"}, mode, m_mode);
         chk({phase, " model oe"}, sdo_oe, m_oe);
         if (m_oe == 1) chk({phase, " model sdo"}, sdo, (out_q.size() > 0) ? out_q[0] : 0);
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b1; wait_n(4);
         sclk = 1'b0; wait_n(4);
      end
   endtask

   task automatic serial(input logic [7:0] val, input int nbits, input logic [7:0] old);
      sel_n = 1'b0; wait_n(4);
      chk("R7 oe after select fall", sdo_oe, 1);
      chk("R7 first bit is old msb", sdo, old[7]);
      for (int i = 0; i < nbits; i++) begin
         int k = 7 - i;
         sdi = (k >= 0) ? val[k] : 1'b0;
         sclk = 1'b0; wait_n(4);
         sclk = 1'b1; wait_n(4);
      end
      sclk = 1'b0; wait_n(4);
      sel_n = 1'b1; wait_n(6);
      chk("R8 R9 oe after select rise", sdo_oe, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; updn = 1'b1; sdi = 1'b0;
      wait_n(3);
      chk("R1 reset code", code, 8'h80);
      chk("R1 reset mode", mode, 0);
      chk("R1 reset oe", sdo_oe, 0);
      chk("R1 reset sdo", sdo, 0);
      rst_n = 1'b1; wait_n(2);
   endtask

   initial begin
      wait_n(1);
      phase = "R1"; do_reset();
      phase = "R2"; pulse(5);
      chk("R2 five increments", code, 8'h85);
      chk("R2 still mode 0", mode, 0);
      phase = "R3"; pulse(130);
      chk("R3 saturate high", code, 8'hFF);

      phase = "R1"; do_reset();
      phase = "R10";
      updn = 1'b0; sclk = 1'b1; wait_n(4);
      chk("R10 coincident pulse counts down", code, 8'h7F);
      chk("R4 entered two-wire", mode, 1);
      sclk = 1'b0; wait_n(4);
      phase = "R5"; updn = 1'b1; wait_n(2);
      pulse(3);
      chk("R5 up steps", code, 8'h82);
      updn = 1'b0; wait_n(2);
      pulse(140);
      chk("R5 saturate low", code, 8'h00);
      phase = "R4"; updn = 1'b1; wait_n(6);
      chk("R4 two-wire sticky", mode, 1);

      phase = "R10";
      sel_n = 1'b0; sclk = 1'b1; wait_n(4);
      chk("R10 coincident select no step", code, 8'h00);
      chk("R6 entered serial from two-wire", mode, 2);
      chk("R7 oe on select", sdo_oe, 1);
      sclk = 1'b0; wait_n(4);
      sel_n = 1'b1; wait_n(6);
      chk("R9 zero-bit frame keeps code", code, 8'h00);

      phase = "R8"; serial(8'hA5, 8, 8'h00);
      chk("R8 load A5", code, 8'hA5);
      phase = "R7"; serial(8'h5A, 8, 8'hA5);
      chk("R8 load 5A", code, 8'h5A);
      phase = "R9"; serial(8'h33, 5, 8'h5A);
      chk("R9 five-bit frame ignored", code, 8'h5A);
      serial(8'h33, 9, 8'h5A);
      chk("R9 nine-bit frame ignored", code, 8'h5A);
      phase = "R6"; updn = 1'b0; pulse(3); updn = 1'b1; pulse(2);
      chk("R6 pulses ignored in serial", code, 8'h5A);
      chk("R6 serial sticky", mode, 2);

      phase = "R1"; do_reset();
      phase = "R6"; pulse(2);
      chk("R2 two increments", code, 8'h82);
      serial(8'h3C, 8, 8'h82);
      chk("R6 serial from mode 0", mode, 2);
      chk("R8 load 3C", code, 8'h3C);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule